// File: doc/BRIEF.md
# Serial Flash DMA Request Generator

This block lives inside a quad-SPI flash controller and turns three internal conditions into per-channel DMA request lines. The conditions are a filled receive buffer, an emptied transmit buffer, and a prefetched word that is ready in the memory-mapped read FIFO. Each condition is held in a flag. A hardware event pulse sets the flag. A register access or a FIFO drain pulse clears it. The shift register, the prefetch FIFO and the DMA controller sit outside the block, so only their event pulses reach it.

Each DMA channel has its own three-bit enable field, one bit per source. A channel's request line is the registered OR of the flags that this channel has enabled. The receive and transmit flags also drive an interrupt line through an interrupt enable register. A source must not request DMA and raise an interrupt at the same time. When software enables both, the block drops the DMA enable for that source and sets a sticky configuration-error bit.

Top module: `sf_dma_req`

## Requirements
- R1: After reset, all three flags, every DMA enable bit, both interrupt enable bits, the error bit, every `dmaReq` bit and `irqReq` are zero.
- R2: A `rxLoadEvt` pulse sets the receive flag. A read of address 0 clears it.
- R3: A `txLoadEvt` pulse sets the transmit flag. A write to address 1 clears it.
- R4: A `fifoWordEvt` pulse sets the FIFO-ready flag. A `fifoDrained` pulse clears it.
- R5: When a set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Address 2 reads and writes the DMA enables. For channel c, bit 3c enables receive, bit 3c+1 enables transmit and bit 3c+2 enables FIFO-ready. Bits above 3·NCH read as zero.
- R7: `dmaReq[c]` is registered. It is high one cycle after a cycle in which some flag and its effective enable for channel c were both set, and low otherwise.
- R8: Address 3 holds the interrupt enables (bit 0 receive, bit 1 transmit). `irqReq` is high one cycle after a cycle in which an enabled receive or transmit flag was set.
- R9: While the interrupt enable of the receive or transmit source is set, that source's DMA enables have no effect on `dmaReq`. If any channel has such a DMA enable set at the same time, the error bit (status bit 3) sets one cycle later and stays set until reset.
- R10: A read of address 4 returns the status: bit 0 receive flag, bit 1 transmit flag, bit 2 FIFO-ready flag, bit 3 error, all other bits zero. Reads of addresses 0, 1 and 5 to 7 return zero. Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLoadEvt | input | 1 | Received word moved into the receive buffer |
| txLoadEvt | input | 1 | Transmit buffer contents moved into the shift register |
| fifoWordEvt | input | 1 | 32-bit word prefetched into the memory-mapped FIFO |
| fifoDrained | input | 1 | FIFO read level has returned to zero |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from stored state |
| dmaReq | output | NCH | Per-channel DMA request lines |
| irqReq | output | 1 | Interrupt request |

## Verification
Read data depends only on stored state, so it is due in the same cycle as the read strobe. The bench samples it one time unit after driving the strobe, before the next rising edge, and compares it with the reference model's state before the update. Flags, enables and the error bit change at the edge that samples the event or access. `dmaReq` and `irqReq` go through one more register, so they follow the pre-edge state one edge later. For this reason the bench computes the expected outputs from the model's old state, then advances the model, and samples one time unit after the edge.

// File: rtl/sf_dma_pkg.sv
package sf_dma_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_RX   = 0;
  localparam int SRC_TX   = 1;
  localparam int SRC_FIFO = 2;

  localparam int ADDR_RXD   = 0;
  localparam int ADDR_TXD   = 1;
  localparam int ADDR_DMAEN = 2;
  localparam int ADDR_IRQEN = 3;
  localparam int ADDR_STAT  = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_DMAEN  = 2'd1,
    SEL_IRQEN  = 2'd2,
    SEL_STATUS = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   clrRx;
    logic   clrTx;
    logic   wrDmaEn;
    logic   wrIrqEn;
    rdSel_e rdSel;
  } regStb_t;
endpackage

// File: rtl/sf_dma_ctrl.sv
module sf_dma_ctrl
  import sf_dma_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStb_t           stb
);
  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    case (int'(regAddr))
      ADDR_RXD:   stb.clrRx   = regRdEn;
      ADDR_TXD:   stb.clrTx   = regWrEn;
      ADDR_DMAEN: begin
        stb.wrDmaEn = regWrEn;
        stb.rdSel   = SEL_DMAEN;
      end
      ADDR_IRQEN: begin
        stb.wrIrqEn = regWrEn;
        stb.rdSel   = SEL_IRQEN;
      end
      ADDR_STAT:  stb.rdSel = SEL_STATUS;
      default:    stb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sf_dma_dp.sv
module sf_dma_dp
  import sf_dma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLoadEvt,
  input  logic              txLoadEvt,
  input  logic              fifoWordEvt,
  input  logic              fifoDrained,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NCH-1:0]    dmaReq,
  output logic              irqReq
);
  localparam int EN_W = NCH * NSRC;

  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] setEvt;
  logic [NSRC-1:0] clrEvt;
  logic [EN_W-1:0] dmaEn;
  logic [1:0]      irqEn;
  logic            cfgErr;
  logic [NCH-1:0]  chConflict;
  logic [NCH-1:0]  reqNext;

  assign setEvt = {fifoWordEvt, txLoadEvt, rxLoadEvt};
  assign clrEvt = {fifoDrained, stb.clrTx, stb.clrRx};

  // Flags: a set event takes priority over a clear in the same cycle
  for (genvar s = 0; s < NSRC; s++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flags[s] <= 1'b0;
      else if (setEvt[s]) flags[s] <= 1'b1;
      else if (clrEvt[s]) flags[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaEn <= '0;
      irqEn <= '0;
    end else begin
      if (stb.wrDmaEn) dmaEn <= regWrData[EN_W-1:0];
      if (stb.wrIrqEn) irqEn <= regWrData[1:0];
    end
  end

  // Per-channel effective enable: interrupt ownership masks DMA
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [NSRC-1:0] chEn;
    logic [NSRC-1:0] effEn;
    assign chEn          = dmaEn[c*NSRC +: NSRC];
    assign effEn         = chEn & ~{1'b0, irqEn};
    assign chConflict[c] = |(chEn[1:0] & irqEn);
    assign reqNext[c]    = |(flags & effEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaReq <= '0;
      irqReq <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      dmaReq <= reqNext;
      irqReq <= |(flags[1:0] & irqEn);
      cfgErr <= cfgErr | (|chConflict);
    end
  end

  always_comb begin
    regRdData = '0;
    case (stb.rdSel)
      SEL_DMAEN:  regRdData[EN_W-1:0] = dmaEn;
      SEL_IRQEN:  regRdData[1:0]      = irqEn;
      SEL_STATUS: regRdData[3:0]      = {cfgErr, flags};
      default:    regRdData           = '0;
    endcase
  end

  // Assertions
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|setEvt) |=> ((flags & $past(setEvt)) == $past(setEvt)));

  p_rx_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrRx && !rxLoadEvt) |=> !flags[SRC_RX]);

  p_tx_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrTx && !txLoadEvt) |=> !flags[SRC_TX]);

  p_req_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaReq) |-> $past(|flags));

  p_irq_masks_dma_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flags == 3'b001 && irqEn[0]) |=> (dmaReq == '0));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

// File: rtl/sf_dma_req.sv
module sf_dma_req
  import sf_dma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLoadEvt,
  input  logic              txLoadEvt,
  input  logic              fifoWordEvt,
  input  logic              fifoDrained,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NCH-1:0]    dmaReq,
  output logic              irqReq
);
  regStb_t stb;

  sf_dma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  sf_dma_dp #(.NCH(NCH), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxLoadEvt   (rxLoadEvt),
    .txLoadEvt   (txLoadEvt),
    .fifoWordEvt (fifoWordEvt),
    .fifoDrained (fifoDrained),
    .stb         (stb),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .dmaReq      (dmaReq),
    .irqReq      (irqReq)
  );
endmodule

// File: tb/sf_dma_req_tb.sv
module sf_dma_req_tb;
  localparam int NCH = 4;
  localparam int EN_W = NCH * 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLoadEvt = 0, txLoadEvt = 0, fifoWordEvt = 0, fifoDrained = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NCH-1:0] dmaReq;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] mFlags;
  logic [EN_W-1:0] mEn;
  logic [1:0] mIrq;
  logic mErr;

  always #2 clk = ~clk;

  sf_dma_req #(.NCH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .rxLoadEvt(rxLoadEvt), .txLoadEvt(txLoadEvt),
    .fifoWordEvt(fifoWordEvt), .fifoDrained(fifoDrained), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .dmaReq(dmaReq), .irqReq(irqReq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] expReq(logic [2:0] f, logic [EN_W-1:0] en, logic [1:0] ie);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = |(f & en[c*3 +: 3] & ~{1'b0, ie});
    return r;
  endfunction

  function automatic logic hasConflict(logic [EN_W-1:0] en, logic [1:0] ie);
    logic k = 1'b0;
    for (int c = 0; c < NCH; c++) k |= |(en[c*3 +: 2] & ie);
    return k;
  endfunction

  function automatic logic [31:0] expRd(logic [2:0] a);
    logic [31:0] d = '0;
    case (a)
      3'd2: d[EN_W-1:0] = mEn;
      3'd3: d[1:0] = mIrq;
      3'd4: d[3:0] = {mErr, mFlags};
      default: d = '0;
    endcase
    return d;
  endfunction

  task automatic step(input logic [3:0] evt, input bit wr, input bit rd,
                      input logic [2:0] a, input logic [31:0] wd, input string tag);
    logic [NCH-1:0] nReq;
    logic nIrq, nErr;
    logic [2:0] clr;
    logic [31:0] e;
    @(negedge clk);
    {fifoDrained, fifoWordEvt, txLoadEvt, rxLoadEvt} = evt;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    #1;
    if (rd) begin
      e = expRd(a);
      chk(regRdData === e, {tag, " read"}, regRdData, e);
    end
    nReq = expReq(mFlags, mEn, mIrq);
    nIrq = |(mFlags[1:0] & mIrq);
    nErr = mErr | hasConflict(mEn, mIrq);
    clr = {evt[3], wr && a == 3'd1, rd && a == 3'd0};
    @(posedge clk);
    #1;
    mFlags = evt[2:0] | (mFlags & ~clr);
    if (wr && a == 3'd2) mEn = wd[EN_W-1:0];
    if (wr && a == 3'd3) mIrq = wd[1:0];
    mErr = nErr;
    chk(dmaReq === nReq, {tag, " R7 dmaReq"}, 32'(dmaReq), 32'(nReq));
    chk(irqReq === nIrq, {tag, " R8 irqReq"}, 32'(irqReq), 32'(nIrq));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mFlags = '0; mEn = '0; mIrq = '0; mErr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRdEn = 1; regAddr = 3'd4; #1;
    chk(regRdData === 32'h0, "R1 status", regRdData, 0);
    regAddr = 3'd2; #1;
    chk(regRdData === 32'h0, "R1 dmaEn", regRdData, 0);
    regAddr = 3'd3; #1;
    chk(regRdData === 32'h0, "R1 irqEn", regRdData, 0);
    chk(dmaReq === '0 && irqReq === 1'b0, "R1 outputs", {dmaReq, irqReq}, 0);
    regRdEn = 0;

    // R6 enables: all channels all sources
    step(4'b0000, 1, 0, 3'd2, 32'hFFFF_FFFF, "R6");
    step(4'b0000, 0, 1, 3'd2, 0, "R6");
    // R2 receive flag
    step(4'b0001, 0, 0, 3'd0, 0, "R2");
    step(4'b0000, 0, 1, 3'd4, 0, "R2");
    step(4'b0000, 0, 1, 3'd0, 0, "R2");
    step(4'b0000, 0, 1, 3'd4, 0, "R2");
    // R3 transmit flag
    step(4'b0010, 0, 0, 3'd0, 0, "R3");
    step(4'b0000, 0, 1, 3'd4, 0, "R3");
    step(4'b0000, 1, 0, 3'd1, 0, "R3");
    step(4'b0000, 0, 1, 3'd4, 0, "R3");
    // R4 FIFO-ready flag
    step(4'b0100, 0, 0, 3'd0, 0, "R4");
    step(4'b0000, 0, 1, 3'd4, 0, "R4");
    step(4'b1000, 0, 0, 3'd0, 0, "R4");
    step(4'b0000, 0, 1, 3'd4, 0, "R4");
    // R5 set beats clear
    step(4'b0001, 0, 1, 3'd0, 0, "R5");
    step(4'b0010, 1, 0, 3'd1, 0, "R5");
    step(4'b1100, 0, 0, 3'd0, 0, "R5");
    step(4'b0000, 0, 1, 3'd4, 0, "R5");
    // R7 per-channel masks
    step(4'b0000, 1, 0, 3'd2, 32'h0000_0A41, "R7");
    step(4'b0000, 1, 1, 3'd0, 0, "R7");
    step(4'b0000, 0, 0, 3'd0, 0, "R7");
    // R8 / R9 interrupt ownership and config error
    step(4'b0001, 1, 0, 3'd3, 32'h1, "R8");
    step(4'b0000, 0, 1, 3'd3, 0, "R8");
    step(4'b0000, 0, 1, 3'd4, 0, "R9");
    step(4'b0000, 1, 0, 3'd3, 32'h0, "R9");
    step(4'b0000, 0, 1, 3'd4, 0, "R9");
    // R10 read-only and unused addresses
    step(4'b0000, 1, 0, 3'd4, 32'h0, "R10");
    step(4'b0000, 0, 1, 3'd4, 0, "R10");
    step(4'b0000, 1, 0, 3'd6, 32'hFFFF_FFFF, "R10");
    step(4'b0000, 0, 1, 3'd5, 0, "R10");
    step(4'b0000, 0, 1, 3'd1, 0, "R10");

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ev;
      logic [2:0] a;
      bit w, r;
      logic [31:0] wd;
      ev = 4'($urandom_range(0, 15)) & {($urandom_range(0, 3) == 0), 3'b111};
      a = 3'($urandom_range(0, 5));
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 1) == 0);
      wd = $urandom();
      if (a == 3'd3 && $urandom_range(0, 3) != 0) wd[1:0] = 2'b00;
      step(ev, w, r, a, wd, r ? "R10" : "R7");
    end

    @(negedge clk);
    {fifoDrained, fifoWordEvt, txLoadEvt, rxLoadEvt} = '0;
    regWrEn = 0; regRdEn = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule